// File: doc/BRIEF.md
# YUV to RGB Color Space Converter

This block turns a stream of 8-bit luma/chroma pixels into 8-bit red, green and blue through a programmable 3x4 fixed-point matrix. Each output channel is one matrix row: three signed multipliers, applied to Y, U and V, plus an additive constant. Pixels enter and leave through valid/ready handshakes. Between the two handshakes sits a three-stage pipeline with a fixed latency, and that pipeline stalls as a whole when the consumer holds back.

Software programs the twelve matrix words through a plain write port into a shadow bank. The datapath reads a separate active bank. That bank takes the shadow contents only on a frame-start pulse, so a frame is never converted with a mix of old and new rows. After reset both banks hold a limited-range BT.601 conversion (Y 16..235, U/V 16..240 to RGB 0..255). A bypass flag that travels with each pixel lets an RGB source pass through the block unchanged.

Top module: `csc_yuv_rgb`

## Requirements
- R1: During reset and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Coefficient word address `4*row + col` selects a row (0 = G, 1 = R, 2 = B) and a column (0, 1, 2 = multipliers of Y, U, V; 3 = constant). After reset both banks hold the defaults:
  - G row: 0x04A7, 0x1E6F, 0x1CBF, 0x0877
  - R row: 0x04A7, 0x0000, 0x0662, 0x3211
  - B row: 0x04A7, 0x0812, 0x0000, 0x2EB1
- R3: Each multiplier is `cfg_wdata[12:0]`, a two's-complement number with 10 fractional bits. Each constant is `cfg_wdata[13:0]`, two's complement with 4 fractional bits, and is shifted left by 6 before it is added. A channel is `floor((Y*m0 + U*m1 + V*m2 + c*64 + 512) / 1024)`.
- R4: A channel result below 0 is output as 0, and a result above 255 is output as 255.
- R5: A pixel accepted with `in_bypass` = 1 leaves with `out_r` = `in_c0`, `out_g` = `in_c1` and `out_b` = `in_c2`.
- R6: Without back-pressure, a pixel accepted at a clock edge shows up on the outputs with `out_valid` = 1 three edges later.
- R7: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and the outputs hold their values.
- R8: Every accepted pixel leaves exactly once, in acceptance order.
- R9: Writes go to the shadow bank only. A pixel accepted before a `frame_start` pulse is converted with the old words, and one accepted after it uses the new words. Writes to addresses 12 to 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 4 | Coefficient word address |
| cfg_wdata | input | 14 | Coefficient word |
| frame_start | input | 1 | Pulse that copies the shadow bank into the active bank |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Converter accepts a pixel this cycle |
| in_bypass | input | 1 | Pass this pixel through unchanged |
| in_c0 | input | 8 | Y (or R in bypass) |
| in_c1 | input | 8 | U (or G in bypass) |
| in_c2 | input | 8 | V (or B in bypass) |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer accepts the output pixel |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |

## Verification
Some properties are checked on every cycle:
- the idle state after reset;
- output hold under back-pressure;
- a bound of three on the pixels in flight;
- a zero result whenever a row's pre-rounding sum is clearly negative.

The remaining properties are shown only by the bench's scenarios, against a reference model:
- the exact channel values for the default and random matrices;
- saturation at both ends;
- the three-cycle latency;
- the bypass mapping;
- the point at which a reload takes effect, including writes to addresses outside the twelve words.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int PIX_W    = 8;
  localparam int MUL_W    = 13;
  localparam int CW       = 14;
  localparam int FRAC     = 10;
  localparam int OFF_FRAC = 4;
  localparam int NROW     = 3;
  localparam int NCOL     = 4;
  localparam int NCOEF    = NROW * NCOL;
  localparam int ADDR_W   = 4;

  // Reset contents: limited-range BT.601, rows G, R, B
  function automatic logic [CW-1:0] default_word(input int idx);
    case (idx)
      0, 4, 8: default_word = 14'h04A7;
      1:       default_word = 14'h1E6F;
      2:       default_word = 14'h1CBF;
      3:       default_word = 14'h0877;
      6:       default_word = 14'h0662;
      7:       default_word = 14'h3211;
      9:       default_word = 14'h0812;
      11:      default_word = 14'h2EB1;
      default: default_word = '0;
    endcase
  endfunction
endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
  import csc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [CW-1:0]         wdata,
  input  logic                  swap,
  output logic [NCOEF*CW-1:0]   act_flat
);
  logic [CW-1:0] shadow [NCOEF];
  logic [CW-1:0] active [NCOEF];

  for (genvar i = 0; i < NCOEF; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        shadow[i] <= default_word(i);
        active[i] <= default_word(i);
      end else begin
        if (we && addr == ADDR_W'(i)) shadow[i] <= wdata;
        if (swap) active[i] <= shadow[i];
      end
    end
    assign act_flat[i*CW +: CW] = active[i];
  end
endmodule

// File: rtl/csc_row.sv
module csc_row
  import csc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PIX_W-1:0]  y,
  input  logic [PIX_W-1:0]  u,
  input  logic [PIX_W-1:0]  v,
  input  logic [MUL_W-1:0]  k0,
  input  logic [MUL_W-1:0]  k1,
  input  logic [MUL_W-1:0]  k2,
  input  logic [CW-1:0]     kc,
  input  logic              byp,
  input  logic [PIX_W-1:0]  byp_val,
  output logic [PIX_W-1:0]  res
);
  localparam int PROD_W = MUL_W + PIX_W + 1;
  localparam int SUM_W  = PROD_W + 2;
  localparam int OFF_SH = FRAC - OFF_FRAC;
  localparam logic signed [SUM_W-1:0] RND  = SUM_W'(1 << (FRAC - 1));
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << PIX_W) - 1);

  logic signed [PROD_W-1:0] p0, p1, p2;
  logic signed [SUM_W-1:0]  cst, sum2, kc_ext, q;
  logic                     byp1, byp2;
  logic [PIX_W-1:0]         bv1, bv2;

  assign kc_ext = SUM_W'($signed(kc));

  // stage 1: products and aligned constant
  always_ff @(posedge clk) begin
    if (rst) begin
      p0 <= '0; p1 <= '0; p2 <= '0; cst <= '0; byp1 <= 1'b0; bv1 <= '0;
    end else if (en) begin
      p0   <= $signed({1'b0, y}) * $signed(k0);
      p1   <= $signed({1'b0, u}) * $signed(k1);
      p2   <= $signed({1'b0, v}) * $signed(k2);
      cst  <= kc_ext <<< OFF_SH;
      byp1 <= byp;
      bv1  <= byp_val;
    end
  end

  // stage 2: row sum
  always_ff @(posedge clk) begin
    if (rst) begin
      sum2 <= '0; byp2 <= 1'b0; bv2 <= '0;
    end else if (en) begin
      sum2 <= SUM_W'(p0) + SUM_W'(p1) + SUM_W'(p2) + cst;
      byp2 <= byp1;
      bv2  <= bv1;
    end
  end

  // stage 3: round, scale, saturate
  assign q = (sum2 + RND) >>> FRAC;

  always_ff @(posedge clk) begin
    if (rst) res <= '0;
    else if (en) begin
      if (byp2)          res <= bv2;
      else if (q < 0)    res <= '0;
      else if (q > MAXV) res <= MAXV[PIX_W-1:0];
      else               res <= q[PIX_W-1:0];
    end
  end

  // R4
  sat_low_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !byp2 && sum2 < -RND) |=> (res == '0));
endmodule

// File: rtl/csc_yuv_rgb.sv
module csc_yuv_rgb
  import csc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [CW-1:0]      cfg_wdata,
  input  logic               frame_start,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_bypass,
  input  logic [PIX_W-1:0]   in_c0,
  input  logic [PIX_W-1:0]   in_c1,
  input  logic [PIX_W-1:0]   in_c2,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [PIX_W-1:0]   out_r,
  output logic [PIX_W-1:0]   out_g,
  output logic [PIX_W-1:0]   out_b
);
  localparam int STAGES = 3;

  logic [NCOEF*CW-1:0] act_flat;
  logic [STAGES-1:0]   vld;
  logic                en;
  logic [PIX_W-1:0]    row_res [NROW];
  logic [PIX_W-1:0]    byp_src [NROW];

  csc_coef_bank u_bank (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .swap(frame_start), .act_flat(act_flat)
  );

  assign en       = out_ready | ~out_valid;
  assign in_ready = en;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (en) vld <= {vld[STAGES-2:0], in_valid};
  end
  assign out_valid = vld[STAGES-1];

  // row 0 = G, row 1 = R, row 2 = B
  assign byp_src[0] = in_c1;
  assign byp_src[1] = in_c0;
  assign byp_src[2] = in_c2;

  for (genvar r = 0; r < NROW; r++) begin : g_row
    csc_row u_row (
      .clk(clk), .rst(rst), .en(en),
      .y(in_c0), .u(in_c1), .v(in_c2),
      .k0(act_flat[(r*NCOL+0)*CW +: MUL_W]),
      .k1(act_flat[(r*NCOL+1)*CW +: MUL_W]),
      .k2(act_flat[(r*NCOL+2)*CW +: MUL_W]),
      .kc(act_flat[(r*NCOL+3)*CW +: CW]),
      .byp(in_bypass), .byp_val(byp_src[r]),
      .res(row_res[r])
    );
  end

  assign out_g = row_res[0];
  assign out_r = row_res[1];
  assign out_b = row_res[2];

  // occupancy tracker for the in-flight bound
  logic [2:0] occ;
  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else occ <= occ + 3'(in_valid && in_ready) - 3'(out_valid && out_ready);
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && in_ready));

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b)));

  // R8
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= 3'(STAGES));
endmodule

// File: tb/sim_csc_yuv_rgb.sv
module sim_csc_yuv_rgb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, frame_start = 0, in_valid = 0, in_bypass = 0, out_ready = 1;
  logic [3:0]  cfg_addr = '0;
  logic [13:0] cfg_wdata = '0;
  logic [7:0]  in_c0 = '0, in_c1 = '0, in_c2 = '0;
  logic in_ready, out_valid;
  logic [7:0] out_r, out_g, out_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  csc_yuv_rgb u0 (.*);

  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;
  int sh [12], act [12];
  logic [23:0] exp_q [$];
  int idx_q [$];
  bit lat_mode = 0, hold_pend = 0;
  logic [23:0] held;

  function automatic int sx(input int w, input int bits);
    return (w >= (1 << (bits-1))) ? w - (1 << bits) : w;
  endfunction

  function automatic int row_val(input int y, u, v, input int r);
    int s, q;
    s = y*sx(act[r*4], 13) + u*sx(act[r*4+1], 13) + v*sx(act[r*4+2], 13)
        + sx(act[r*4+3], 14) * 64;
    q = (s + 512) >>> 10;
    if (q < 0) q = 0;
    if (q > 255) q = 255;
    return q;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [23:0] got, exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s got %06h expected %06h", req, got, exp);
    end
  endtask

  task automatic cycle(input logic iv, input logic [7:0] a, b, c,
                       input logic byp, input logic ordy, output bit acc);
    logic [23:0] e, g;
    @(negedge clk);
    in_valid = iv; in_c0 = a; in_c1 = b; in_c2 = c; in_bypass = byp; out_ready = ordy;
    #1;
    acc = in_valid && in_ready;
    g = {out_r, out_g, out_b};
    if (hold_pend) chk(out_valid && g == held, "R7 hold", g, held);
    if (out_valid && !out_ready) chk(!in_ready, "R7 in_ready", {23'd0, in_ready}, 24'd0);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(0, "R8 extra pixel", g, 24'd0);
      else begin
        e = exp_q.pop_front();
        chk(g == e, "R2/R3/R4/R5/R8 data", g, e);
        if (lat_mode) chk(cyc - idx_q[0] == 3, "R6 latency", 24'(cyc - idx_q[0]), 24'd3);
        void'(idx_q.pop_front());
      end
    end
    hold_pend = out_valid && !out_ready;
    held = g;
    if (acc) begin
      if (byp) e = {a, b, c};
      else e = {8'(row_val(a, b, c, 1)), 8'(row_val(a, b, c, 0)), 8'(row_val(a, b, c, 2))};
      exp_q.push_back(e);
      idx_q.push_back(cyc);
    end
    cyc++;
  endtask

  task automatic send(input logic [7:0] a, b, c, input logic byp);
    bit acc = 0;
    while (!acc) cycle(1, a, b, c, byp, 1, acc);
  endtask

  task automatic drain();
    bit acc;
    for (int k = 0; k < 20 && exp_q.size() > 0; k++) cycle(0, 0, 0, 0, 0, 1, acc);
    chk(exp_q.size() == 0, "R8 drained", 24'(exp_q.size()), 24'd0);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = 14'(d);
    @(negedge clk); cfg_we = 0;
    if (a < 12) sh[a] = d;
  endtask

  task automatic pulse();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    for (int i = 0; i < 12; i++) act[i] = sh[i];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    bit acc;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 12; i++) begin
      sh[i] = 0; act[i] = 0;
    end
    // R2 defaults
    sh[0]=32'h4A7; sh[1]=32'h1E6F; sh[2]=32'h1CBF; sh[3]=32'h877;
    sh[4]=32'h4A7; sh[6]=32'h662; sh[7]=32'h3211;
    sh[8]=32'h4A7; sh[9]=32'h812; sh[11]=32'h2EB1;
    for (int i = 0; i < 12; i++) act[i] = sh[i];
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!out_valid && in_ready, "R1 in reset", {22'd0, out_valid, in_ready}, 24'd1);
    rst = 0;
    @(negedge clk);
    chk(!out_valid && in_ready, "R1 after reset", {22'd0, out_valid, in_ready}, 24'd1);

    // R2/R3 default matrix, R6 latency
    lat_mode = 1;
    send(16, 128, 128, 0); drain();
    send(235, 128, 128, 0); drain();
    send(81, 90, 240, 0); drain();
    send(145, 54, 34, 0); drain();
    // R4 saturation both ways
    send(0, 0, 0, 0); drain();
    send(255, 255, 255, 0); drain();
    // R5 bypass
    send(8'h12, 8'h34, 8'h56, 1); drain();
    send(8'hFF, 8'h00, 8'hA5, 1); drain();
    lat_mode = 0;

    // R7/R8 random stream with back-pressure
    for (int n = 0; n < 600; n++)
      cycle($urandom_range(0, 3) != 0, 8'($urandom), 8'($urandom), 8'($urandom),
            $urandom_range(0, 5) == 0, $urandom_range(0, 2) != 0, acc);
    drain();

    // R9 reload: shadow writes do not reach pixels before frame_start
    for (int rep = 0; rep < 4; rep++) begin
      for (int i = 0; i < 12; i++) begin
        int d;
        d = (i % 4 == 3) ? int'($urandom_range(0, 16383))
                         : int'($urandom_range(0, 1023)) + (($urandom_range(0, 3) == 0) ? 7168 : 0);
        wr(i, d);
      end
      wr(13, 14'h3FFF);   // R9 out-of-range address ignored
      for (int k = 0; k < 6; k++) send(8'($urandom), 8'($urandom), 8'($urandom), 0);
      drain();
      pulse();
      for (int k = 0; k < 30; k++)
        cycle(1, 8'($urandom), 8'($urandom), 8'($urandom), 0, $urandom_range(0, 3) != 0, acc);
      drain();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule